// File: doc/BRIEF.md
# Burst Write Redirection Controller

This block lets a DMA engine that writes only to one fixed 32-bit data port reach many internal registers. Six 16-bit update masks select the targets. Mask 0 covers the master group and masks 1 to 5 cover timer groups A to E. Target bit b of mask g has the flat index 16*g + b.

On a trigger the block walks the flat mask vector from index 0 upward. For each set bit it raises a DMA request, and it routes the next data-port write to that target. Clear bits are skipped without a request. When no set bit is left, the burst is over and the block waits for the next trigger.

A data-port write that arrives while idle also starts a burst. That write is consumed by the first selected target.

The data port is a valid/ready stream sink. A beat transfers on a rising edge where `dport_valid` and `dport_ready` are both high. `dport_ready` is high only when a selected target is waiting for data, and it is low in any cycle in which a mask is being written. The DMA engine may hold `dport_valid` low for as long as it likes. The request then simply stays up.

Writing any mask aborts a burst that is running and returns the parser to index 0. There is no enable bit.

Top module: `burst_redirect`

## Requirements
- R1: After reset all masks are zero, `dma_req`, `done` and `tgt_we` are low, and `dport_ready` is low.
- R2: A burst visits set mask bits in ascending flat order 16*g + b, where g runs from 0 (master) to 5 (group E) and b runs from 0 to 15. It raises exactly one request-and-write per set bit.
- R3: One cycle after each accepted data beat, exactly the bit of `tgt_we` at the current target's flat index is high for one cycle, and `tgt_data` equals the beat's data. `tgt_we` is all zero in every other cycle.
- R4: Targets whose mask bit is clear receive no write during a burst.
- R5: `dma_req` stays high, and no target write occurs, for as long as `dport_valid` is held low during a burst.
- R6: In the cycle after the final beat of a burst is accepted, `done` is high for one cycle and `dma_req` is low, unless R8 applies.
- R7: A trigger that arrives while a request other than the last one is outstanding is dropped. No second burst follows.
- R8: A trigger that arrives while the last request of a burst is outstanding is kept. In the cycle after the final beat, `done` is high and `dma_req` is high again for a new burst that starts at index 0.
- R9: A data beat offered while idle, with at least one mask bit set, is accepted. It is routed to the lowest set index, and the burst continues with requests for the remaining set bits.
- R10: A mask write drives `dport_ready` low in its own cycle. It clears `dma_req` in the next cycle, and the next trigger restarts the walk from index 0.
- R11: A trigger with all masks zero produces a one-cycle `done` pulse in the next cycle, with no request and no write.
- R12: While idle with all masks zero, `dport_ready` is low and an offered beat causes no target write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mask write strobe; aborts any running burst |
| cfg_sel | input | 3 | Mask index: 0 master, 1..5 timer groups A..E |
| cfg_data | input | 16 | New mask value |
| trig | input | 1 | Burst trigger, one pulse per request |
| dma_req | output | 1 | DMA request: a target is waiting for data |
| dport_valid | input | 1 | Data port beat valid |
| dport_ready | output | 1 | Data port ready |
| dport_data | input | 32 | Data port beat |
| tgt_we | output | 96 | One-hot target write enables, flat index 16*g + b |
| tgt_data | output | 32 | Data for the enabled target |
| done | output | 1 | One-cycle pulse when a burst completes |

## Verification
A table of mask patterns drives complete bursts, and each pattern tells apart a different class of fault:
- A single bit at the very first index and a single bit at the very last index expose off-by-one errors in the walk.
- A pattern that is sparse across groups, and one that is dense inside a group, separate group-to-group carry faults from bit-order faults.

Directed sequences then cover the timing cases:
- held-off valid, to check that the request is held;
- a trigger during a request that is not the last one, and a trigger during the last one, to check that the trigger filter is two-sided;
- a burst started by an idle write;
- an abort through a mask write, followed by a restart;
- an empty burst.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bdr_state_e;
endpackage

// File: rtl/bdr_mask_bank.sv
// Six (NG) update masks, written one at a time, presented as one flat vector.
module bdr_mask_bank #(
  parameter int NG = 6,
  parameter int NB = 16,
  localparam int SW = $clog2(NG),
  localparam int NT = NG * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_sel,
  input  logic [NB-1:0] cfg_data,
  output logic [NT-1:0] flat
);
  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [NB-1:0] mask_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mask_q <= '0;
      else if (cfg_we && cfg_sel == SW'(g))
        mask_q <= cfg_data;
    end
    assign flat[g*NB +: NB] = mask_q;
  end
endmodule

// File: rtl/bdr_seek.sv
// Combinational find-first: lowest set bit at or above the cursor, and whether it is the final one.
module bdr_seek #(
  parameter int NT = 96,
  localparam int CW = $clog2(NT + 1)
) (
  input  logic [NT-1:0] flat,
  input  logic [CW-1:0] cursor,
  output logic          found,
  output logic          last,
  output logic [CW-1:0] idx
);
  logic [NT-1:0] masked;
  logic [NT-1:0] lowest;
  logic [NT-1:0] rest;

  assign masked = flat & ({NT{1'b1}} << cursor);
  assign lowest = masked & (~masked + NT'(1));
  assign rest   = masked & (masked - NT'(1));
  assign found  = |masked;
  assign last   = found && (rest == '0);

  always_comb begin
    idx = '0;
    for (int i = 0; i < NT; i++) begin
      if (lowest[i]) idx = idx | CW'(i);
    end
  end
endmodule

// File: rtl/bdr_seq.sv
// Burst sequencer: walk cursor, trigger filter with one pending slot, completion pulse.
module bdr_seq
  import bdr_pkg::*;
#(
  parameter int NT = 96,
  localparam int CW = $clog2(NT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          trig,
  input  logic          accept,
  input  logic          found,
  input  logic          last,
  input  logic [CW-1:0] idx,
  output logic          run,
  output logic [CW-1:0] cursor,
  output logic          done
);
  bdr_state_e state_q;
  logic       pend_q;
  logic       finish;

  assign run    = (state_q == ST_RUN);
  assign finish = accept && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cursor  <= '0;
      pend_q  <= 1'b0;
      done    <= 1'b0;
    end else if (cfg_we) begin
      state_q <= ST_IDLE;
      cursor  <= '0;
      pend_q  <= 1'b0;
      done    <= 1'b0;
    end else if (finish) begin
      state_q <= (pend_q || trig) ? ST_RUN : ST_IDLE;
      cursor  <= '0;
      pend_q  <= 1'b0;
      done    <= 1'b1;
    end else if (accept) begin
      state_q <= ST_RUN;
      cursor  <= idx + CW'(1);
      done    <= 1'b0;
    end else if (run) begin
      pend_q  <= pend_q || (trig && last);
      done    <= 1'b0;
    end else begin
      if (trig && found) state_q <= ST_RUN;
      done <= trig && !found;
    end
  end
endmodule

// File: rtl/bdr_route.sv
// Registered write demultiplexer to the target registers.
module bdr_route #(
  parameter int NT = 96,
  parameter int DW = 32,
  localparam int CW = $clog2(NT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [CW-1:0] idx,
  input  logic [DW-1:0] data,
  output logic [NT-1:0] tgt_we,
  output logic [DW-1:0] tgt_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_we   <= '0;
      tgt_data <= '0;
    end else begin
      tgt_we <= fire ? (NT'(1) << idx) : '0;
      if (fire) tgt_data <= data;
    end
  end
endmodule

// File: rtl/burst_redirect.sv
module burst_redirect #(
  parameter int NG = 6,
  parameter int NB = 16,
  parameter int DW = 32,
  localparam int NT = NG * NB,
  localparam int SW = $clog2(NG),
  localparam int CW = $clog2(NT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_sel,
  input  logic [NB-1:0] cfg_data,
  input  logic          trig,
  output logic          dma_req,
  input  logic          dport_valid,
  output logic          dport_ready,
  input  logic [DW-1:0] dport_data,
  output logic [NT-1:0] tgt_we,
  output logic [DW-1:0] tgt_data,
  output logic          done
);
  logic [NT-1:0] flat;
  logic [CW-1:0] cursor;
  logic [CW-1:0] idx;
  logic          found;
  logic          last;
  logic          accept;

  bdr_mask_bank #(.NG(NG), .NB(NB)) bank_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .flat(flat)
  );

  bdr_seek #(.NT(NT)) seek_i (
    .flat(flat), .cursor(cursor), .found(found), .last(last), .idx(idx)
  );

  // Ready whenever a selected target is waiting; a mask write blocks the beat.
  assign dport_ready = !cfg_we && found;
  assign accept      = dport_valid && dport_ready;

  bdr_seq #(.NT(NT)) seq_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .trig(trig), .accept(accept),
    .found(found), .last(last), .idx(idx), .run(dma_req), .cursor(cursor),
    .done(done)
  );

  bdr_route #(.NT(NT), .DW(DW)) route_i (
    .clk(clk), .rst_n(rst_n), .fire(accept), .idx(idx), .data(dport_data),
    .tgt_we(tgt_we), .tgt_data(tgt_data)
  );
endmodule

// File: rtl/burst_redirect_chk.sv
module burst_redirect_chk #(
  parameter int NT = 96,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          dma_req,
  input logic          dport_valid,
  input logic          dport_ready,
  input logic [DW-1:0] dport_data,
  input logic [NT-1:0] tgt_we,
  input logic [DW-1:0] tgt_data
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_we));

  p_write_after_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dport_valid && dport_ready) |=> ($countones(tgt_we) == 1 && tgt_data == $past(dport_data)));

  p_no_stray_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dport_valid && dport_ready) |=> (tgt_we == '0));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dport_valid && !cfg_we) |=> dma_req);

  p_cfg_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !dport_ready);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !dma_req);
endmodule

bind burst_redirect burst_redirect_chk #(.NT(NT), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .dma_req(dma_req),
  .dport_valid(dport_valid), .dport_ready(dport_ready), .dport_data(dport_data),
  .tgt_we(tgt_we), .tgt_data(tgt_data)
);

// File: tb/burst_redirect_tb_top.sv
module burst_redirect_tb_top;
  localparam int NT = 96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [15:0]   cfg_data = '0;
  logic          trig = 1'b0;
  logic          dma_req;
  logic          dport_valid = 1'b0;
  logic          dport_ready;
  logic [31:0]   dport_data = '0;
  logic [NT-1:0] tgt_we;
  logic [31:0]   tgt_data;
  logic          done;

  int  n_chk = 0;
  int  n_err = 0;
  bit  finished = 1'b0;
  logic [NT-1:0] shadow = '0;

  always #5 clk = ~clk;

  burst_redirect dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .trig(trig), .dma_req(dma_req), .dport_valid(dport_valid), .dport_ready(dport_ready),
    .dport_data(dport_data), .tgt_we(tgt_we), .tgt_data(tgt_data), .done(done)
  );

  // Mask patterns, flat index 16*g + b; group 0 in the low 16 bits.
  localparam logic [NT-1:0] VEC [4] = '{
    96'h0000_0000_0000_0000_0000_0001,
    96'h8000_0000_0000_0000_0000_0000,
    96'h0000_00FF_0000_F00F_0000_0000,
    96'h1234_0000_8001_0000_0000_A5A5
  };

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  function automatic int next_set(input logic [NT-1:0] v, input int from);
    for (int i = from; i < NT; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic set_mask(input int g, input logic [15:0] v);
    cfg_we = 1'b1; cfg_sel = 3'(g); cfg_data = v;
    shadow[g*16 +: 16] = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_all(input logic [NT-1:0] v);
    for (int g = 0; g < 6; g++) set_mask(g, v[g*16 +: 16]);
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  // Offer one beat with dma_req up; check the routed write one cycle later.
  task automatic serve(input logic [31:0] d, input int exp_idx, input string tag);
    dport_valid = 1'b1; dport_data = d;
    @(negedge clk);
    dport_valid = 1'b0;
    chk(tgt_we == (NT'(1) << exp_idx), {tag, " target"}, tgt_we, NT'(1) << exp_idx);
    chk(tgt_data == d, {tag, " data"}, tgt_data, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int pos;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(dma_req == 1'b0, "R1 req", dma_req, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(tgt_we == '0, "R1 tgt_we", tgt_we, 0);
    chk(dport_ready == 1'b0, "R1 ready", dport_ready, 0);

    // R2 R3 R4 R6: table of mask patterns, each run as a full burst
    for (int r = 0; r < 4; r++) begin
      load_all(VEC[r]);
      pulse_trig();
      chk(dma_req == 1'b1, "R2 req raised", dma_req, 1);
      pos = next_set(shadow, 0);
      while (pos >= 0) begin
        serve(32'(r * 4096 + pos), pos, "R2 R3 R4 walk");
        pos = next_set(shadow, pos + 1);
        if (pos >= 0) chk(dma_req == 1'b1, "R2 req between", dma_req, 1);
      end
      chk(done == 1'b1, "R6 done", done, 1);
      chk(dma_req == 1'b0, "R6 req low", dma_req, 0);
      @(negedge clk);
      chk(done == 1'b0, "R6 done pulse", done, 0);
    end

    // R5: held-off valid keeps the request and writes nothing
    load_all(96'h0);
    set_mask(0, 16'h0005);
    pulse_trig();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(dma_req == 1'b1, "R5 held", dma_req, 1);
      chk(tgt_we == '0, "R5 no write", tgt_we, 0);
    end
    serve(32'hA0, 0, "R5");
    serve(32'hA2, 2, "R5");

    // R7: trigger during a non-final request is dropped
    @(negedge clk);
    pulse_trig();
    pulse_trig();
    serve(32'hB0, 0, "R7");
    serve(32'hB2, 2, "R7");
    chk(dma_req == 1'b0, "R7 dropped", dma_req, 0);
    @(negedge clk);
    chk(dma_req == 1'b0, "R7 still idle", dma_req, 0);

    // R8: trigger during the last request is kept
    pulse_trig();
    serve(32'hC0, 0, "R8");
    pulse_trig();
    serve(32'hC2, 2, "R8");
    chk(done == 1'b1, "R8 done", done, 1);
    chk(dma_req == 1'b1, "R8 restart", dma_req, 1);
    serve(32'hC4, 0, "R8 second");
    serve(32'hC6, 2, "R8 second");
    chk(dma_req == 1'b0, "R8 end", dma_req, 0);

    // R9: idle write starts a burst
    @(negedge clk);
    serve(32'hD0, 0, "R9 first");
    chk(dma_req == 1'b1, "R9 continues", dma_req, 1);
    serve(32'hD2, 2, "R9");
    chk(done == 1'b1, "R9 done", done, 1);

    // R10: mask write aborts and restarts from index 0
    set_mask(2, 16'h0100);
    pulse_trig();
    serve(32'hE0, 0, "R10 pre");
    cfg_we = 1'b1; cfg_sel = 3'd3; cfg_data = 16'h0000; dport_valid = 1'b1;
    #1;
    chk(dport_ready == 1'b0, "R10 ready blocked", dport_ready, 0);
    @(negedge clk);
    cfg_we = 1'b0; dport_valid = 1'b0;
    chk(tgt_we == '0, "R10 no write", tgt_we, 0);
    chk(dma_req == 1'b0, "R10 aborted", dma_req, 0);
    pulse_trig();
    serve(32'hE1, 0, "R10 restart");
    serve(32'hE2, 2, "R10");
    serve(32'hE3, 40, "R10");
    chk(done == 1'b1, "R10 done", done, 1);

    // R11: empty burst
    load_all(96'h0);
    pulse_trig();
    chk(done == 1'b1, "R11 done", done, 1);
    chk(dma_req == 1'b0, "R11 no req", dma_req, 0);
    @(negedge clk);
    chk(done == 1'b0, "R11 pulse", done, 0);

    // R12: idle with no set bits refuses beats
    dport_valid = 1'b1; dport_data = 32'hF0;
    #1;
    chk(dport_ready == 1'b0, "R12 ready", dport_ready, 0);
    @(negedge clk);
    dport_valid = 1'b0;
    chk(tgt_we == '0, "R12 no write", tgt_we, 0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule